// File: doc/BRIEF.md
# Raw Pixel Black-Level and Gain Stage

This block is the front of a raw Bayer processing chain. Each 10-bit sensor sample first has a programmable pedestal removed, so that sensor black becomes code zero. It is then multiplied by a digital gain between x1 and x8. A second programmable offset is added back near the output. A slot for lens shading correction sits between the gain and the addition and currently passes data straight through. Every arithmetic step clamps to the code range rather than wrapping.

Under configuration control, a built-in pattern source can replace the gained stream. It offers a flat colour, a horizontal ramp and a set of vertical bars. The pattern follows the line and frame markers that arrive with the input stream. The pipeline depth is fixed at three cycles, and the valid and marker signals travel alongside the data with the same delay.

Top module: `pix_level_gain`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `outValid`, `outSol` and `outSof` are low and `outData` is zero.
- R2: `outValid`, `outSol` and `outSof` reproduce `inValid`, `inSol` and `inSof` exactly three clock cycles later, for every cycle.
- R3: With pattern mode 0, an input at or below `cfgBlackSub` produces the value `cfgBlackAdd` (zero when the offset is zero); the subtraction never wraps.
- R4: With pattern mode 0, the gained value is round((in - sub) * g / 32), with halves rounded upward, clamped to 1023. Here g is `cfgGain` read as an unsigned number with 3 integer and 5 fraction bits.
- R5: A `cfgGain` code below 32 (below x1.0) acts as exactly 32, so the gain never drops under unity.
- R6: The output is the shading-slot value plus `cfgBlackAdd`, clamped to 1023.
- R7: Pattern mode 1 outputs `cfgPatColor` plus `cfgBlackAdd` (clamped) for every valid pixel, regardless of `inData`.
- R8: Pattern mode 2 outputs the pixel's column index modulo 1024, plus `cfgBlackAdd` (clamped).
- R9: Pattern mode 3 outputs bars 80 columns wide. The bar index is column/80, capped at 7. The level is index*146, plus `cfgBlackAdd` (clamped).
- R10: The column index is 0 for a valid pixel that carries `inSol` or `inSof`. It rises by one for each later valid pixel. Cycles with `inValid` low neither advance the index nor restart it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input sample valid |
| inSol | input | 1 | First pixel of a line |
| inSof | input | 1 | First pixel of a frame |
| inData | input | 10 | Raw sample |
| cfgBlackSub | input | 10 | Pedestal removed before gain |
| cfgGain | input | 8 | Digital gain, 3.5 unsigned fixed point |
| cfgBlackAdd | input | 10 | Offset added at the output |
| cfgPatMode | input | 2 | 0 live, 1 flat colour, 2 ramp, 3 bars |
| cfgPatColor | input | 10 | Flat-colour level |
| outValid | output | 1 | Output sample valid |
| outSol | output | 1 | Delayed line-start marker |
| outSof | output | 1 | Delayed frame-start marker |
| outData | output | 10 | Processed sample |

## Verification
The bench targets the clamping points. A pedestal above the sample must give zero, not a wrapped large value. A product past 1023 must clamp rather than keep its low bits. An offset that overflows must saturate. Rounding is probed at exact half and quarter fractions: a design that truncates returns 1 instead of 2 for 1.5. Sub-unity gain codes are tested because a design without the floor would darken the image. For the patterns, the bench runs ramps past 1024 columns, bar lines longer than eight bars, and line restarts mid-line with idle gaps. An off-by-one column counter or one that counts idle cycles shifts every ramp value and bar edge.

// File: rtl/pix_lg_pkg.sv
package pix_lg_pkg;

  typedef enum logic [1:0] {
    PAT_OFF   = 2'd0,
    PAT_SOLID = 2'd1,
    PAT_RAMP  = 2'd2,
    PAT_BARS  = 2'd3
  } patModeT;

  // strobes handed from control to datapath, one set per input cycle
  typedef struct packed {
    logic vld;
    logic sol;
    logic sof;
    logic usePat;
  } lgStrobeT;

endpackage

// File: rtl/pix_lg_ctrl.sv
module pix_lg_ctrl
  import pix_lg_pkg::*;
#(
  parameter int PIX_W    = 10,
  parameter int BAR_W    = 80,
  parameter int NUM_BARS = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inSol,
  input  logic             inSof,
  input  logic [1:0]       cfgPatMode,
  input  logic [PIX_W-1:0] cfgPatColor,
  output lgStrobeT         strb,
  output logic [PIX_W-1:0] patVal
);
  localparam int BAR_CW   = (BAR_W > 1) ? $clog2(BAR_W) : 1;
  localparam int IDX_W    = (NUM_BARS > 1) ? $clog2(NUM_BARS) : 1;
  localparam int BAR_STEP = ((1 << PIX_W) - 1) / ((NUM_BARS > 1) ? (NUM_BARS - 1) : 1);
  localparam logic [BAR_CW-1:0] BAR_LAST = BAR_CW'(BAR_W - 1);
  localparam logic [IDX_W-1:0]  IDX_LAST = IDX_W'(NUM_BARS - 1);

  patModeT mode;
  logic lineStart;
  logic [PIX_W-1:0]  colCnt, colNow;
  logic [BAR_CW-1:0] barCnt, barNow;
  logic [IDX_W-1:0]  idxCnt, idxNow;

  assign mode      = patModeT'(cfgPatMode);
  assign lineStart = inValid & (inSol | inSof);

  always_comb begin
    colNow = lineStart ? '0 : colCnt;
    barNow = lineStart ? '0 : barCnt;
    idxNow = lineStart ? '0 : idxCnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      colCnt <= '0;
      barCnt <= '0;
      idxCnt <= '0;
    end else if (inValid) begin
      colCnt <= colNow + 1'b1;
      if (barNow == BAR_LAST) begin
        barCnt <= '0;
        idxCnt <= (idxNow == IDX_LAST) ? idxNow : idxNow + 1'b1;
      end else begin
        barCnt <= barNow + 1'b1;
        idxCnt <= idxNow;
      end
    end
  end

  always_comb begin
    case (mode)
      PAT_SOLID: patVal = cfgPatColor;
      PAT_RAMP:  patVal = colNow;
      PAT_BARS:  patVal = PIX_W'(int'(idxNow) * BAR_STEP);
      default:   patVal = '0;
    endcase
  end

  always_comb begin
    strb.vld    = inValid;
    strb.sol    = inSol;
    strb.sof    = inSof;
    strb.usePat = (mode != PAT_OFF);
  end

endmodule

// File: rtl/pix_lg_dpath.sv
module pix_lg_dpath
  import pix_lg_pkg::*;
#(
  parameter int PIX_W     = 10,
  parameter int GAIN_W    = 8,
  parameter int GAIN_FRAC = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  lgStrobeT          strb,
  input  logic [PIX_W-1:0]  patVal,
  input  logic [PIX_W-1:0]  inData,
  input  logic [PIX_W-1:0]  cfgBlackSub,
  input  logic [GAIN_W-1:0] cfgGain,
  input  logic [PIX_W-1:0]  cfgBlackAdd,
  output logic              outValid,
  output logic              outSol,
  output logic              outSof,
  output logic [PIX_W-1:0]  outData
);
  localparam int LAT    = 3;
  localparam int PROD_W = PIX_W + GAIN_W;
  localparam logic [GAIN_W-1:0]  GAIN_ONE = GAIN_W'(1 << GAIN_FRAC);
  localparam logic [PROD_W:0]    HALF     = (PROD_W+1)'(1 << (GAIN_FRAC - 1));
  localparam logic [PIX_W-1:0]   PIX_MAX  = {PIX_W{1'b1}};

  // stage 1: pedestal removal, pattern capture
  logic [PIX_W-1:0] s1Data, s1Pat;
  logic             s1Use;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Data <= '0;
      s1Pat  <= '0;
      s1Use  <= 1'b0;
    end else begin
      s1Data <= (inData > cfgBlackSub) ? inData - cfgBlackSub : '0;
      s1Pat  <= patVal;
      s1Use  <= strb.usePat;
    end
  end

  // stage 2: gain with round-half-up and clamp, pattern mux
  logic [GAIN_W-1:0] gainEff;
  logic [PROD_W-1:0] prod;
  logic [PROD_W:0]   rnd;
  logic [PIX_W-1:0]  gained, s2Data;

  always_comb begin
    gainEff = (cfgGain < GAIN_ONE) ? GAIN_ONE : cfgGain;
    prod    = PROD_W'(s1Data) * PROD_W'(gainEff);
    rnd     = ({1'b0, prod} + HALF) >> GAIN_FRAC;
    gained  = (rnd > (PROD_W+1)'(PIX_MAX)) ? PIX_MAX : rnd[PIX_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) s2Data <= '0;
    else       s2Data <= s1Use ? s1Pat : gained;
  end

  // lens shading slot: pass-through for now
  logic [PIX_W-1:0] shadeData;
  assign shadeData = s2Data;

  // stage 3: offset addition with clamp
  logic [PIX_W:0] sum;
  assign sum = {1'b0, shadeData} + {1'b0, cfgBlackAdd};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outData <= '0;
    else       outData <= sum[PIX_W] ? PIX_MAX : sum[PIX_W-1:0];
  end

  // marker delay line matching the data stages
  logic [2:0] markPipe [LAT];
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < LAT; i++) markPipe[i] <= '0;
    end else begin
      markPipe[0] <= {strb.vld, strb.sol, strb.sof};
      for (int i = 1; i < LAT; i++) markPipe[i] <= markPipe[i-1];
    end
  end

  assign {outValid, outSol, outSof} = markPipe[LAT-1];

endmodule

// File: rtl/pix_level_gain.sv
module pix_level_gain
  import pix_lg_pkg::*;
#(
  parameter int PIX_W     = 10,
  parameter int GAIN_W    = 8,
  parameter int GAIN_FRAC = 5,
  parameter int BAR_W     = 80,
  parameter int NUM_BARS  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              inSol,
  input  logic              inSof,
  input  logic [PIX_W-1:0]  inData,
  input  logic [PIX_W-1:0]  cfgBlackSub,
  input  logic [GAIN_W-1:0] cfgGain,
  input  logic [PIX_W-1:0]  cfgBlackAdd,
  input  logic [1:0]        cfgPatMode,
  input  logic [PIX_W-1:0]  cfgPatColor,
  output logic              outValid,
  output logic              outSol,
  output logic              outSof,
  output logic [PIX_W-1:0]  outData
);
  lgStrobeT         strb;
  logic [PIX_W-1:0] patVal;

  pix_lg_ctrl #(.PIX_W(PIX_W), .BAR_W(BAR_W), .NUM_BARS(NUM_BARS)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSol(inSol), .inSof(inSof),
    .cfgPatMode(cfgPatMode), .cfgPatColor(cfgPatColor),
    .strb(strb), .patVal(patVal)
  );

  pix_lg_dpath #(.PIX_W(PIX_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .patVal(patVal), .inData(inData),
    .cfgBlackSub(cfgBlackSub), .cfgGain(cfgGain), .cfgBlackAdd(cfgBlackAdd),
    .outValid(outValid), .outSol(outSol), .outSof(outSof), .outData(outData)
  );

endmodule

// File: rtl/pix_lg_check.sv
module pix_lg_check #(
  parameter int PIX_W = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             inSol,
  input logic             inSof,
  input logic [PIX_W-1:0] inData,
  input logic [PIX_W-1:0] cfgBlackSub,
  input logic [PIX_W-1:0] cfgBlackAdd,
  input logic [1:0]       cfgPatMode,
  input logic [PIX_W-1:0] cfgPatColor,
  input logic             outValid,
  input logic             outSol,
  input logic             outSof,
  input logic [PIX_W-1:0] outData
);
  logic [1:0] seen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             seen <= '0;
    else if (seen != 2'd3) seen <= seen + 1'b1;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) !rstN |=> (!outValid && !outSol && !outSof && outData == '0)); // R1

  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rstN)
    (seen == 2'd3) |-> (outValid == $past(inValid, 3))); // R2

  AST_SOL_DELAY: assert property (@(posedge clk) disable iff (!rstN)
    (seen == 2'd3) |-> (outSol == $past(inSol, 3))); // R2

  AST_SOF_DELAY: assert property (@(posedge clk) disable iff (!rstN)
    (seen == 2'd3) |-> (outSof == $past(inSof, 3))); // R2

  AST_SUB_FLOOR: assert property (@(posedge clk) disable iff (!rstN)
    (seen == 2'd3 && $past(cfgPatMode, 3) == 2'd0 && $past(inData, 3) <= $past(cfgBlackSub, 3)
     && $past(cfgBlackAdd, 1) == '0) |-> (outData == '0)); // R3

  AST_ADD_FLOOR: assert property (@(posedge clk) disable iff (!rstN)
    (seen != 2'd0) |-> (outData >= $past(cfgBlackAdd, 1))); // R6

  AST_SOLID_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    (seen == 2'd3 && $past(cfgPatMode, 3) == 2'd1 && $past(cfgBlackAdd, 1) == '0)
    |-> (outData == $past(cfgPatColor, 3))); // R7

endmodule

bind pix_level_gain pix_lg_check #(.PIX_W(PIX_W)) u_chk (.*);

// File: tb/test_pix_level_gain.sv
module test_pix_level_gain;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0, inSol = 1'b0, inSof = 1'b0;
  logic [9:0] inData = '0;
  logic [9:0] cfgBlackSub = '0, cfgBlackAdd = '0, cfgPatColor = '0;
  logic [7:0] cfgGain = 8'd32;
  logic [1:0] cfgPatMode = '0;
  logic       outValid, outSol, outSof;
  logic [9:0] outData;

  int total = 0, bad = 0, cyc = 0, colM = 0;
  string curReq = "R4";
  logic [2:0] expM [4];
  int         expD [4];
  string      expT [4];
  bit done = 0;

  always #4 clk = ~clk;

  pix_level_gain i_pix_level_gain (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSol(inSol), .inSof(inSof),
    .inData(inData), .cfgBlackSub(cfgBlackSub), .cfgGain(cfgGain),
    .cfgBlackAdd(cfgBlackAdd), .cfgPatMode(cfgPatMode), .cfgPatColor(cfgPatColor),
    .outValid(outValid), .outSol(outSol), .outSof(outSof), .outData(outData)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int model(int d, int col);
    int y, g, idx;
    case (int'(cfgPatMode))
      0: begin
        y = (d > int'(cfgBlackSub)) ? d - int'(cfgBlackSub) : 0;
        g = (cfgGain < 8'd32) ? 32 : int'(cfgGain);
        y = (y * g + 16) >> 5;
        if (y > 1023) y = 1023;
      end
      1: y = int'(cfgPatColor);
      2: y = col % 1024;
      default: begin
        idx = col / 80;
        if (idx > 7) idx = 7;
        y = idx * 146;
      end
    endcase
    y = y + int'(cfgBlackAdd);
    return (y > 1023) ? 1023 : y;
  endfunction

  task automatic step(input bit v, input bit sl, input bit sf, input int d);
    int slot, c;
    @(negedge clk);
    if (cyc >= 3) begin
      slot = (cyc + 1) % 4;
      chk("R2", int'({outValid, outSol, outSof}), int'(expM[slot]));
      if (expM[slot][2]) chk(expT[slot], int'(outData), expD[slot]);
    end
    inValid = v; inSol = sl; inSof = sf; inData = 10'(d);
    c = 0;
    if (v) begin
      c = (sl || sf) ? 0 : colM;
      colM = c + 1;
    end
    expM[cyc % 4] = {v, sl, sf};
    expD[cyc % 4] = model(d, c);
    expT[cyc % 4] = curReq;
    cyc++;
  endtask

  task automatic flush();
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0);
  endtask

  task automatic setLive(int sub, int gain, int add);
    flush();
    cfgPatMode = 2'd0; cfgBlackSub = 10'(sub); cfgGain = 8'(gain); cfgBlackAdd = 10'(add);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1", int'({outValid, outSol, outSof}), 0);
    chk("R1", int'(outData), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", int'({outValid, outSol, outSof}), 0);
    chk("R1", int'(outData), 0);

    // R3: pedestal at or above sample
    curReq = "R3"; setLive(64, 32, 0);
    step(1, 1, 1, 50); step(1, 0, 0, 64); step(1, 0, 0, 65); step(1, 0, 0, 1023); step(1, 0, 0, 0);
    // R4: rounding at exact halves and quarters, then clamp
    curReq = "R4"; setLive(0, 48, 0);
    step(1, 1, 0, 1); step(1, 0, 0, 3); step(1, 0, 0, 682); step(1, 0, 0, 683);
    setLive(0, 40, 0);
    step(1, 1, 0, 1); step(1, 0, 0, 2); step(1, 0, 0, 6);
    setLive(10, 255, 0);
    step(1, 1, 0, 1000); step(1, 0, 0, 138); step(1, 0, 0, 139);
    // R5: sub-unity gain codes
    curReq = "R5"; setLive(0, 0, 0);
    step(1, 1, 0, 500); step(1, 0, 0, 1023);
    setLive(0, 31, 0);
    step(1, 1, 0, 777); step(1, 0, 0, 1);
    // R6: offset clamp
    curReq = "R6"; setLive(0, 32, 1000);
    step(1, 1, 0, 600); step(1, 0, 0, 23); step(1, 0, 0, 22); step(1, 0, 0, 0);
    // R7: flat colour ignores input
    curReq = "R7"; flush(); cfgPatMode = 2'd1; cfgPatColor = 10'd333; cfgBlackAdd = '0;
    for (int i = 0; i < 20; i++) step(1, i == 0, 0, int'($urandom % 1024));
    flush(); cfgBlackAdd = 10'd10;
    for (int i = 0; i < 10; i++) step(1, 0, 0, int'($urandom % 1024));
    flush(); cfgPatColor = 10'd1020;
    for (int i = 0; i < 5; i++) step(1, 0, 0, 0);
    // R8: ramp longer than 1024 columns, with idle gaps
    curReq = "R8"; flush(); cfgPatMode = 2'd2; cfgBlackAdd = '0;
    for (int i = 0; i < 1100; i++) begin
      step(1, i == 0, 0, 0);
      if (i % 97 == 5) step(0, 0, 0, 0);
    end
    // R9: bars beyond the last bar
    curReq = "R9"; flush(); cfgPatMode = 2'd3;
    for (int i = 0; i < 700; i++) step(1, i == 0, 0, 0);
    // R10: restart mid-line, idle markers ignored, frame start
    curReq = "R10"; flush(); cfgPatMode = 2'd2;
    step(1, 1, 0, 0); step(1, 0, 0, 0); step(1, 0, 0, 0);
    step(0, 0, 0, 0); step(1, 0, 0, 0);
    step(1, 1, 0, 0); step(1, 0, 0, 0);
    step(1, 0, 1, 0); step(1, 0, 0, 0); step(1, 0, 0, 0);
    // random blocks
    for (int b = 0; b < 24; b++) begin
      flush();
      cfgPatMode  = 2'($urandom % 4);
      cfgBlackSub = 10'($urandom % 200);
      cfgGain     = 8'($urandom);
      cfgBlackAdd = 10'(($urandom % 4 == 0) ? $urandom % 1024 : $urandom % 64);
      cfgPatColor = 10'($urandom);
      case (int'(cfgPatMode))
        0: curReq = "R4";
        1: curReq = "R7";
        2: curReq = "R8";
        default: curReq = "R9";
      endcase
      for (int i = 0; i < 300; i++) begin
        bit v;
        v = ($urandom % 4) != 0;
        step(v, v && ($urandom % 60 == 0), v && ($urandom % 200 == 0), int'($urandom % 1024));
      end
    end
    flush();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule